// File: doc/BRIEF.md
# Three-Step Logarithmic Motion Search Controller

This block steers a three-step logarithmic block-matching search for a single 16x16 macroblock. After a start pulse it produces a sequence of candidate displacements, one at a time, each a signed (dx, dy) pair. An external unit computes the matching cost for each candidate and sends the cost back. The controller keeps the cheapest candidate it has seen. At the end of each step it moves the search centre to that candidate. After the last step it presents the motion vector and raises a one-cycle done pulse. Fetching pixels, holding frames and computing the cost all happen outside this block.

The stride halves from one step to the next: 4, then 2, then 1. The centre itself is requested only in the first step. In the later steps the cost of the centre is already known, because it was the best result of the step before. The search therefore covers a window of plus or minus 7 pixels and needs exactly 25 cost evaluations. A candidate travels on a valid/ready request channel. Its cost comes back on a valid-only response channel.

FSM states and transitions:
- IDLE: start → ISSUE. This also clears the best-cost record and resets the centre, step and point index.
- ISSUE: request accepted → WAIT.
- WAIT: cost received for a point that is not the last of its step → ISSUE. Cost received for the last point → ADVANCE.
- ADVANCE: the centre takes the best point. On the final step → DONE. On any other step → ISSUE, with the step advanced and the index set to the first neighbour.
- DONE: → IDLE.

Top module: `tss_search_ctrl`

## Requirements
- R1: After reset, req_valid_o and done_o are 0, and mv_dx_o and mv_dy_o are 0.
- R2: The first step issues the centre (0,0) first. It then issues the eight neighbours at stride 4 in this order, as (dx,dy) unit offsets times the stride: (-1,-1),(0,-1),(1,-1),(-1,0),(1,0),(-1,1),(0,1),(1,1).
- R3: The second step issues only the eight neighbours, in the R2 order at stride 2, around the lowest-cost point of the first step. The centre is not issued again.
- R4: The third step issues the eight neighbours in the R2 order at stride 1 around the lowest-cost point of the second step. The lowest-cost point of the third step is the motion vector.
- R5: Every search issues exactly 25 requests. done_o is high for exactly one cycle, and it rises two cycles after the 25th cost is taken.
- R6: When two costs are equal, the candidate evaluated earlier is kept. A centre therefore wins any tie against its neighbours.
- R7: A request keeps req_valid_o and its displacement stable until req_ready_i is seen high. After acceptance, no new request is issued until the matching cost has arrived on cost_valid_i.
- R8: A start_i pulse while a search is running has no effect on the requested sequence or on the result.
- R9: Displacements and motion vector components are 4-bit two's complement values within -7..+7. The motion vector stays on mv_dx_o and mv_dy_o after done_o until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a search when the block is idle |
| req_valid_o | output | 1 | Candidate request valid |
| req_ready_i | input | 1 | Cost unit accepts the request |
| req_dx_o | output | 4 | Candidate horizontal displacement, two's complement |
| req_dy_o | output | 4 | Candidate vertical displacement, two's complement |
| cost_valid_i | input | 1 | Cost response valid |
| cost_i | input | 16 | Matching cost of the last accepted candidate |
| done_o | output | 1 | One-cycle search-complete pulse |
| mv_dx_o | output | 4 | Motion vector horizontal component |
| mv_dy_o | output | 4 | Motion vector vertical component |

## Verification
Two functions can land in the same cycle: taking a cost response, and seeing a stray start pulse. They can also collide while a request is being stalled. The bench drives start_i high in the very cycle that cost_valid_i delivers a response, and also in a cycle where req_ready_i is held low. In both cases it compares the complete 25-entry request sequence and the final vector against an independent model of the search. A merged event would show up as a restarted sequence, a repeated centre request, or a lost cost.

// File: rtl/tss_pkg.sv
package tss_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_ADVANCE,
        ST_DONE
    } tss_state_e;

    // Point index 0 is the centre; 1..8 walk the 3x3 grid in raster order, skipping the middle.
    function automatic int grid_pos(input logic [3:0] idx);
        int k;
        k = (idx <= 4'd4) ? int'(idx) - 1 : int'(idx);
        return k;
    endfunction

    function automatic int unit_x(input logic [3:0] idx);
        if (idx == 4'd0) return 0;
        return (grid_pos(idx) % 3) - 1;
    endfunction

    function automatic int unit_y(input logic [3:0] idx);
        if (idx == 4'd0) return 0;
        return (grid_pos(idx) / 3) - 1;
    endfunction

endpackage

// File: rtl/tss_cand_gen.sv
module tss_cand_gen
    import tss_pkg::*;
#(
    parameter int STEPS  = 3,
    parameter int MV_W   = STEPS + 1,
    parameter int STEP_W = 2
) (
    input  logic signed [MV_W-1:0]   centre_dx_i,
    input  logic signed [MV_W-1:0]   centre_dy_i,
    input  logic        [STEP_W-1:0] step_i,
    input  logic        [3:0]        idx_i,
    output logic signed [MV_W-1:0]   cand_dx_o,
    output logic signed [MV_W-1:0]   cand_dy_o
);
    localparam int FIRST_STRIDE = 1 << (STEPS - 1);

    int stride;
    int sum_x;
    int sum_y;

    always_comb begin
        stride    = FIRST_STRIDE >> step_i;
        sum_x     = int'(centre_dx_i) + unit_x(idx_i) * stride;
        sum_y     = int'(centre_dy_i) + unit_y(idx_i) * stride;
        cand_dx_o = MV_W'(sum_x);
        cand_dy_o = MV_W'(sum_y);
    end

endmodule

// File: rtl/tss_best_trk.sv
module tss_best_trk #(
    parameter int MV_W   = 4,
    parameter int COST_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear_i,
    input  logic                   load_i,
    input  logic signed [MV_W-1:0] cand_dx_i,
    input  logic signed [MV_W-1:0] cand_dy_i,
    input  logic [COST_W-1:0]      cost_i,
    output logic signed [MV_W-1:0] best_dx_o,
    output logic signed [MV_W-1:0] best_dy_o
);
    logic [COST_W-1:0] best_cost;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_cost <= '1;
            best_dx_o <= '0;
            best_dy_o <= '0;
        end else if (clear_i) begin
            best_cost <= '1;
            best_dx_o <= '0;
            best_dy_o <= '0;
        end else if (load_i && (cost_i < best_cost)) begin
            best_cost <= cost_i;
            best_dx_o <= cand_dx_i;
            best_dy_o <= cand_dy_i;
        end
    end

    AST_BEST_NONINC: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> best_cost <= $past(best_cost)); // R4

    AST_TIE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clear_i && cost_i == best_cost) |=> ($stable(best_dx_o) && $stable(best_dy_o))); // R6

endmodule

// File: rtl/tss_search_ctrl.sv
module tss_search_ctrl
    import tss_pkg::*;
#(
    parameter int STEPS  = 3,
    parameter int COST_W = 16,
    parameter int MV_W   = STEPS + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [MV_W-1:0]   req_dx_o,
    output logic [MV_W-1:0]   req_dy_o,
    input  logic              cost_valid_i,
    input  logic [COST_W-1:0] cost_i,
    output logic              done_o,
    output logic [MV_W-1:0]   mv_dx_o,
    output logic [MV_W-1:0]   mv_dy_o
);
    localparam int STEP_W  = (STEPS > 2) ? $clog2(STEPS) : 1;
    localparam int EVALS   = 9 + 8 * (STEPS - 1);
    localparam int CNT_W   = $clog2(EVALS + 1);
    localparam int RANGE   = (1 << STEPS) - 1;
    localparam logic [3:0] LAST_IDX = 4'd8;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

    tss_state_e state_q, state_d;

    logic [STEP_W-1:0]      step_q;
    logic [3:0]             idx_q;
    logic signed [MV_W-1:0] centre_dx_q, centre_dy_q;
    logic signed [MV_W-1:0] cand_dx, cand_dy;
    logic signed [MV_W-1:0] best_dx, best_dy;
    logic                   take_start, take_cost, accept;

    assign take_start = (state_q == ST_IDLE) && start_i;
    assign take_cost  = (state_q == ST_WAIT) && cost_valid_i;
    assign accept     = (state_q == ST_ISSUE) && req_ready_i;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_ISSUE;
            ST_ISSUE:   if (req_ready_i) state_d = ST_WAIT;
            ST_WAIT:    if (cost_valid_i) state_d = (idx_q == LAST_IDX) ? ST_ADVANCE : ST_ISSUE;
            ST_ADVANCE: state_d = (step_q == LAST_STEP) ? ST_DONE : ST_ISSUE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Search position registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q      <= '0;
            idx_q       <= '0;
            centre_dx_q <= '0;
            centre_dy_q <= '0;
        end else if (take_start) begin
            step_q      <= '0;
            idx_q       <= '0;
            centre_dx_q <= '0;
            centre_dy_q <= '0;
        end else if (take_cost && idx_q != LAST_IDX) begin
            idx_q <= idx_q + 4'd1;
        end else if (state_q == ST_ADVANCE) begin
            centre_dx_q <= best_dx;
            centre_dy_q <= best_dy;
            if (step_q != LAST_STEP) begin
                step_q <= step_q + 1'b1;
                idx_q  <= 4'd1;
            end
        end
    end

    // Output logic
    always_comb begin
        req_valid_o = (state_q == ST_ISSUE);
        done_o      = (state_q == ST_DONE);
        req_dx_o    = cand_dx;
        req_dy_o    = cand_dy;
        mv_dx_o     = centre_dx_q;
        mv_dy_o     = centre_dy_q;
    end

    tss_cand_gen #(
        .STEPS  (STEPS),
        .MV_W   (MV_W),
        .STEP_W (STEP_W)
    ) u_cand (
        .centre_dx_i (centre_dx_q),
        .centre_dy_i (centre_dy_q),
        .step_i      (step_q),
        .idx_i       (idx_q),
        .cand_dx_o   (cand_dx),
        .cand_dy_o   (cand_dy)
    );

    tss_best_trk #(
        .MV_W   (MV_W),
        .COST_W (COST_W)
    ) u_best (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (take_start),
        .load_i    (take_cost),
        .cand_dx_i (cand_dx),
        .cand_dy_i (cand_dy),
        .cost_i    (cost_i),
        .best_dx_o (best_dx),
        .best_dy_o (best_dy)
    );

    // Accepted-request counter, used only by the checks below
    logic [CNT_W-1:0] acc_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          acc_cnt <= '0;
        else if (take_start) acc_cnt <= '0;
        else if (accept)     acc_cnt <= acc_cnt + 1'b1;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_dx_o) && $stable(req_dy_o))); // R7

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ready_i) |=> !req_valid_o); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5

    AST_EVAL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (acc_cnt == CNT_W'(EVALS))); // R5

    AST_MV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($signed(mv_dx_o) >= -RANGE && $signed(mv_dx_o) <= RANGE &&
                    $signed(mv_dy_o) >= -RANGE && $signed(mv_dy_o) <= RANGE)); // R9

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && start_i && !cost_valid_i) |=>
            (state_q == ST_WAIT && $stable(idx_q) && $stable(step_q))); // R8

endmodule

// File: tb/tb_tss_search_ctrl.sv
module tb_tss_search_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        req_valid_o;
    logic        req_ready_i = 1'b0;
    logic [3:0]  req_dx_o, req_dy_o;
    logic        cost_valid_i = 1'b0;
    logic [15:0] cost_i = '0;
    logic        done_o;
    logic [3:0]  mv_dx_o, mv_dy_o;

    always #2 clk = ~clk;   // 250 MHz

    tss_search_ctrl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .req_valid_o  (req_valid_o),
        .req_ready_i  (req_ready_i),
        .req_dx_o     (req_dx_o),
        .req_dy_o     (req_dy_o),
        .cost_valid_i (cost_valid_i),
        .cost_i       (cost_i),
        .done_o       (done_o),
        .mv_dx_o      (mv_dx_o),
        .mv_dy_o      (mv_dy_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int tx, ty, wx, wy;
    int exp_x [25];
    int exp_y [25];
    int exp_mvx, exp_mvy;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int cost_of(input int x, input int y);
        return wx * iabs(x - tx) + wy * iabs(y - ty);
    endfunction

    function automatic int sx4(input logic [3:0] v);
        return int'($signed(v));
    endfunction

    // Independent model of the search built from R2..R4 and R6
    task automatic build_expected();
        int ux[8] = '{-1, 0, 1, -1, 1, -1, 0, 1};
        int uy[8] = '{-1, -1, -1, 0, 0, 1, 1, 1};
        int cx = 0, cy = 0, bx = 0, by = 0, best, n = 0;
        exp_x[0] = 0; exp_y[0] = 0; n = 1;
        best = cost_of(0, 0);
        for (int s = 4; s >= 1; s = s / 2) begin
            for (int k = 0; k < 8; k++) begin
                int px = cx + ux[k] * s;
                int py = cy + uy[k] * s;
                int c  = cost_of(px, py);
                exp_x[n] = px; exp_y[n] = py; n++;
                if (c < best) begin best = c; bx = px; by = py; end
            end
            cx = bx; cy = by;
        end
        exp_mvx = cx; exp_mvy = cy;
    endtask

    // Serves one full search; stall = ready-low cycles, lat = extra cost latency,
    // stray_at = request index whose cost cycle also carries a start pulse (-1 none),
    // stray_stall_at = request index whose stall carries a start pulse (-1 none).
    task automatic run_search(input string name, input int stall, input int lat,
                              input int stray_at, input int stray_stall_at);
        int seen = 0;
        int dones = 0;
        build_expected();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int i = 0; i < 25; i++) begin
            int wait_n = 0;
            while (!req_valid_o && wait_n < 20) begin @(negedge clk); wait_n++; end
            if (!req_valid_o) begin
                check(0, {name, " R5 request missing"}, i, 25);
                return;
            end
            seen++;
            check(sx4(req_dx_o) == exp_x[i] && sx4(req_dy_o) == exp_y[i],
                  (i == 0) ? {name, " R2 centre first"} :
                  (i < 9)  ? {name, " R2 step-1 order"} :
                  (i < 17) ? {name, " R3 step-2 order"} : {name, " R4 step-3 order"},
                  sx4(req_dx_o) * 100 + sx4(req_dy_o), exp_x[i] * 100 + exp_y[i]);
            for (int h = 0; h < stall; h++) begin
                logic [3:0] hx = req_dx_o, hy = req_dy_o;
                if (i == stray_stall_at && h == 0) start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                check(req_valid_o && req_dx_o == hx && req_dy_o == hy,
                      {name, " R7 hold while stalled"}, {req_valid_o, req_dx_o}, {1'b1, hx});
            end
            req_ready_i = 1'b1;
            @(negedge clk);
            req_ready_i = 1'b0;
            check(!req_valid_o, {name, " R7 no request while cost pending"}, req_valid_o, 0);
            for (int d = 0; d < lat; d++) begin
                @(negedge clk);
                check(!req_valid_o, {name, " R7 no request while cost pending"}, req_valid_o, 0);
            end
            cost_valid_i = 1'b1;
            cost_i = 16'(cost_of(exp_x[i], exp_y[i]));
            if (i == stray_at) start_i = 1'b1;   // R8 stray start with cost
            @(negedge clk);
            cost_valid_i = 1'b0;
            start_i = 1'b0;
            if (i == 24) check(!done_o, {name, " R5 done timing"}, done_o, 0);
        end
        // R5: done one cycle after the ADVANCE cycle
        @(negedge clk);
        check(done_o && !req_valid_o, {name, " R5 done pulse"}, {done_o, req_valid_o}, 2);
        check(sx4(mv_dx_o) == exp_mvx, {name, " R4 mv dx"}, sx4(mv_dx_o), exp_mvx);
        check(sx4(mv_dy_o) == exp_mvy, {name, " R4 mv dy"}, sx4(mv_dy_o), exp_mvy);
        if (done_o) dones++;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (done_o) dones++;
            check(!req_valid_o, {name, " R5 no extra request"}, req_valid_o, 0);
        end
        check(dones == 1, {name, " R5 single done"}, dones, 1);
        check(sx4(mv_dx_o) == exp_mvx && sx4(mv_dy_o) == exp_mvy,
              {name, " R9 mv held"}, sx4(mv_dx_o) * 100 + sx4(mv_dy_o), exp_mvx * 100 + exp_mvy);
        check(seen == 25, {name, " R5 request count"}, seen, 25);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!req_valid_o, "R1 req_valid reset", req_valid_o, 0);
        check(!done_o, "R1 done reset", done_o, 0);
        check(mv_dx_o == 4'd0 && mv_dy_o == 4'd0, "R1 mv reset", {mv_dx_o, mv_dy_o}, 0);
    endtask

    task automatic t_plain();       tx = 5;  ty = -3; wx = 3; wy = 5; run_search("plain",  0, 0, -1, -1); endtask
    task automatic t_corner();      tx = -7; ty = 7;  wx = 2; wy = 2; run_search("corner R9", 2, 3, -1, -1); endtask
    task automatic t_flat_tie();    tx = 0;  ty = 0;  wx = 0; wy = 0; run_search("flat R6", 1, 0, -1, -1); endtask
    task automatic t_centre_tie();  tx = 2;  ty = 0;  wx = 1; wy = 1; run_search("centre R6", 0, 1, -1, -1); endtask
    task automatic t_stray_start(); tx = -6; ty = -1; wx = 4; wy = 1; run_search("stray R8", 1, 1, 12, 5); endtask
    task automatic t_far();         tx = 7;  ty = -7; wx = 1; wy = 3; run_search("far R9", 0, 2, 0, -1); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain();
        t_corner();
        t_flat_tie();
        t_centre_tie();
        t_stray_start();
        t_far();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R5 actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule